// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between a host write port and a flash array controller. It watches single-cycle bus writes, each an address of 17 bits and a data byte, and recognises the multi-write unlock sequences that start an operation. A finished sequence becomes a one-cycle operation request carrying a kind code, a target address and a data byte. The recognised operations are byte program, page erase, chip erase, entry into identification mode, and the return to normal reads.

A protected boot region of 32 pages of 512 bytes sits at the high or the low end of the array. The parameter `BOOT_AT_TOP` chooses the end. The region is guarded whenever the `prot_en` input is high, and no write sequence can lift that guard. While identification mode is active, a read port returns the maker code bytes, a device code that depends on the variant, and the protection state.

While the status block holds `busy_i` high, command writes are dropped.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `op_valid` and `id_mode` are 0 and `id_rdata` reads 00h.
- R2: The unlock writes are AAh and then 55h. Only address bits 14:0 are compared, against 5555h for the first write and 2AAAh for the second. Bits 16:15 are ignored.
- R3: The unlock writes, then A0h at 5555h, then a fourth write at any address form a byte program. On the clock edge that accepts the fourth write, `op_valid` rises with `op_kind`=0 and with that write's address and data. A data byte of F0h in the fourth write is programmed like any other byte.
- R4: The unlock writes, then 80h at 5555h, then AAh at 5555h and 55h at 2AAAh, then 30h at any address form a page erase. The request has `op_kind`=1, `op_addr` = the write address with bits 8:0 cleared, and `op_data`=FFh.
- R5: The same erase prefix, ending instead in 10h at 5555h, forms a chip erase with `op_kind`=2, `op_addr`=0 and `op_data`=FFh.
- R6: A write that does not match the next expected step returns the decoder to idle without issuing a request. The matching of a later sequence is not affected.
- R7: While `busy_i` is high, writes change no state, issue no request and do not change `id_mode`.
- R8: When `prot_en` is high, program and page erase requests aimed at a protected page are dropped. With `BOOT_AT_TOP`=1 the protected pages are 224 to 255 (addresses 1C000h and up). With `BOOT_AT_TOP`=0 they are pages 0 to 31 (addresses below 4000h).
- R9: When `prot_en` is high, a chip erase is dropped entirely.
- R10: The unlock writes followed by 90h at 5555h set `id_mode`. In ID mode, `id_rdata` returns 7Fh for `rd_addr`[1:0]=00 and 1Fh for 11. For 01 it returns A5h when `BOOT_AT_TOP`=1 and A6h when `BOOT_AT_TOP`=0. Outside ID mode, `id_rdata` is 00h.
- R11: In ID mode, `rd_addr`[1:0]=10 returns `prot_en` in bit 0, with bits 7:1 at zero.
- R12: A write of F0h at any address clears `id_mode` and returns the decoder to idle. The one exception is the data slot of a byte program.
- R13: `op_valid` is high for exactly one cycle per accepted sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | A bus write is presented this cycle |
| wr_addr | input | 17 | Write address |
| wr_data | input | 8 | Write data byte |
| busy_i | input | 1 | Array operation in progress; writes are dropped |
| prot_en | input | 1 | Boot region guard enable |
| rd_addr | input | 17 | Read address for identification reads |
| op_valid | output | 1 | One-cycle operation request |
| op_kind | output | 2 | 0 program, 1 page erase, 2 chip erase |
| op_addr | output | 17 | Target address (page base for page erase) |
| op_data | output | 8 | Program byte, or FFh for erases |
| id_mode | output | 1 | Identification mode active |
| id_rdata | output | 8 | Identification read data |

## Verification
Suppose the sequencer held a wrong state, for example it stayed mid-sequence after a mismatch, or it advanced on a write made during busy. The next well-formed command would then issue a request one write early, one write late, or not at all. That fault shows on `op_valid` on the edge after that command's last write. A wrong ID-mode flag shows at once, on the combinational `id_rdata` for any read address. An error in the protection window shows only when a request lands on pages 31/32 or 223/224, so those boundaries are written on both variants.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    OPK_PROGRAM = 2'd0,
    OPK_PAGE    = 2'd1,
    OPK_CHIP    = 2'd2
  } opk_e;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_KEY1, SQ_KEY2, SQ_PGM, SQ_ER1, SQ_ER2, SQ_ER3
  } sq_e;

  // Page lies inside the guarded boot window at one end of the array.
  function automatic logic page_locked(input int unsigned page,
                                       input int unsigned n_pages,
                                       input int unsigned n_locked,
                                       input bit at_top);
    if (at_top) return page >= (n_pages - n_locked);
    return page < n_locked;
  endfunction

  // Identification byte selected by the two low read address bits.
  function automatic logic [7:0] id_byte(input logic [1:0] sel,
                                         input bit at_top,
                                         input logic guard);
    case (sel)
      2'b00:   return 8'h7F;
      2'b01:   return at_top ? 8'hA5 : 8'hA6;
      2'b10:   return {7'd0, guard};
      default: return 8'h1F;
    endcase
  endfunction

endpackage

// File: rtl/fcd_seq.sv
module fcd_seq #(
  parameter int AW       = 17,
  parameter int CMD_BITS = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          busy_i,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  output logic          fire_prog,
  output logic          fire_page,
  output logic          fire_chip,
  output logic          seq_break,
  output logic          in_prog,
  output logic          id_mode
);
  import flash_cmd_pkg::*;

  localparam logic [CMD_BITS-1:0] KEY_A = CMD_BITS'(15'h5555);
  localparam logic [CMD_BITS-1:0] KEY_B = CMD_BITS'(15'h2AAA);

  sq_e  st_q, st_d;
  logic take, at_a, at_b, quit, id_enter;

  assign take    = wr_en & ~busy_i;
  assign at_a    = wr_addr[CMD_BITS-1:0] == KEY_A;
  assign at_b    = wr_addr[CMD_BITS-1:0] == KEY_B;
  assign in_prog = st_q == SQ_PGM;
  assign quit    = take & (wr_data == 8'hF0) & ~in_prog;

  always_comb begin
    st_d      = st_q;
    fire_prog = 1'b0;
    fire_page = 1'b0;
    fire_chip = 1'b0;
    seq_break = 1'b0;
    id_enter  = 1'b0;
    if (quit) begin
      st_d = SQ_IDLE;
    end else if (take) begin
      st_d = SQ_IDLE;
      case (st_q)
        SQ_IDLE: if (at_a && wr_data == 8'hAA) st_d = SQ_KEY1;
        SQ_KEY1: if (at_b && wr_data == 8'h55) st_d = SQ_KEY2;
                 else seq_break = 1'b1;
        SQ_KEY2: begin
          if (at_a && wr_data == 8'hA0)      st_d = SQ_PGM;
          else if (at_a && wr_data == 8'h80) st_d = SQ_ER1;
          else if (at_a && wr_data == 8'h90) id_enter = 1'b1;
          else seq_break = 1'b1;
        end
        SQ_PGM:  fire_prog = 1'b1;
        SQ_ER1:  if (at_a && wr_data == 8'hAA) st_d = SQ_ER2;
                 else seq_break = 1'b1;
        SQ_ER2:  if (at_b && wr_data == 8'h55) st_d = SQ_ER3;
                 else seq_break = 1'b1;
        SQ_ER3: begin
          if (wr_data == 8'h30)              fire_page = 1'b1;
          else if (at_a && wr_data == 8'h10) fire_chip = 1'b1;
          else seq_break = 1'b1;
        end
        default: st_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      id_mode <= 1'b0;
    end else begin
      st_q <= st_d;
      if (quit)          id_mode <= 1'b0;
      else if (id_enter) id_mode <= 1'b1;
    end
  end

endmodule

// File: rtl/fcd_prot.sv
module fcd_prot #(
  parameter int AW          = 17,
  parameter int PAGE_BITS   = 9,
  parameter int LOCK_PAGES  = 32,
  parameter bit BOOT_AT_TOP = 1'b1
) (
  input  logic [1:0]    kind,
  input  logic [AW-1:0] addr,
  input  logic          prot_en,
  output logic          deny
);
  import flash_cmd_pkg::*;

  localparam int PN_BITS = AW - PAGE_BITS;
  localparam int N_PAGES = 1 << PN_BITS;

  logic [PN_BITS-1:0] page;
  logic               hit;

  assign page = addr[AW-1:PAGE_BITS];
  assign hit  = page_locked(32'(page), N_PAGES, LOCK_PAGES, BOOT_AT_TOP);
  assign deny = prot_en & ((kind == OPK_CHIP) | hit);

endmodule

// File: rtl/fcd_id.sv
module fcd_id #(
  parameter int AW          = 17,
  parameter bit BOOT_AT_TOP = 1'b1
) (
  input  logic          id_mode,
  input  logic          prot_en,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    id_rdata
);
  import flash_cmd_pkg::*;

  assign id_rdata = id_mode ? id_byte(rd_addr[1:0], BOOT_AT_TOP, prot_en) : 8'h00;

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int AW          = 17,
  parameter int PAGE_BITS   = 9,
  parameter int LOCK_PAGES  = 32,
  parameter int CMD_BITS    = 15,
  parameter bit BOOT_AT_TOP = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          busy_i,
  input  logic          prot_en,
  input  logic [AW-1:0] rd_addr,
  output logic          op_valid,
  output logic [1:0]    op_kind,
  output logic [AW-1:0] op_addr,
  output logic [7:0]    op_data,
  output logic          id_mode,
  output logic [7:0]    id_rdata
);
  import flash_cmd_pkg::*;

  localparam logic [AW-1:0] OFS_MASK = AW'((1 << PAGE_BITS) - 1);

  logic          fire_prog, fire_page, fire_chip, seq_break, in_prog;
  logic          fire_any, deny, grant;
  logic [1:0]    req_kind;
  logic [AW-1:0] req_addr;
  logic [7:0]    req_data;

  fcd_seq #(.AW(AW), .CMD_BITS(CMD_BITS)) seq_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .busy_i(busy_i),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .fire_prog(fire_prog), .fire_page(fire_page), .fire_chip(fire_chip),
    .seq_break(seq_break), .in_prog(in_prog), .id_mode(id_mode)
  );

  always_comb begin
    req_kind = OPK_PROGRAM;
    req_addr = wr_addr;
    req_data = wr_data;
    if (fire_page) begin
      req_kind = OPK_PAGE;
      req_addr = wr_addr & ~OFS_MASK;
      req_data = 8'hFF;
    end else if (fire_chip) begin
      req_kind = OPK_CHIP;
      req_addr = '0;
      req_data = 8'hFF;
    end
  end

  fcd_prot #(.AW(AW), .PAGE_BITS(PAGE_BITS), .LOCK_PAGES(LOCK_PAGES),
             .BOOT_AT_TOP(BOOT_AT_TOP)) prot_i (
    .kind(req_kind), .addr(req_addr), .prot_en(prot_en), .deny(deny)
  );

  assign fire_any = fire_prog | fire_page | fire_chip;
  assign grant    = fire_any & ~deny;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_valid <= 1'b0;
      op_kind  <= OPK_PROGRAM;
      op_addr  <= '0;
      op_data  <= '0;
    end else begin
      op_valid <= grant;
      if (grant) begin
        op_kind <= req_kind;
        op_addr <= req_addr;
        op_data <= req_data;
      end
    end
  end

  fcd_id #(.AW(AW), .BOOT_AT_TOP(BOOT_AT_TOP)) id_i (
    .id_mode(id_mode), .prot_en(prot_en), .rd_addr(rd_addr), .id_rdata(id_rdata)
  );

endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
  parameter int AW          = 17,
  parameter int PAGE_BITS   = 9,
  parameter int LOCK_PAGES  = 32,
  parameter bit BOOT_AT_TOP = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [7:0]    wr_data,
  input logic          busy_i,
  input logic          prot_en,
  input logic          op_valid,
  input logic [1:0]    op_kind,
  input logic [AW-1:0] op_addr,
  input logic          id_mode,
  input logic [7:0]    id_rdata,
  input logic          seq_break,
  input logic          in_prog
);
  import flash_cmd_pkg::*;

  localparam int N_PAGES = 1 << (AW - PAGE_BITS);

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> !op_valid); // R13

  AST_BUSY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> (!op_valid && $stable(id_mode))); // R7

  AST_BREAK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    seq_break |=> !op_valid); // R6

  AST_PAGE_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == OPK_PAGE) |-> op_addr[PAGE_BITS-1:0] == '0); // R4

  AST_CHIP_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == OPK_CHIP) |-> !$past(prot_en)); // R9

  AST_BOOT_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && $past(prot_en)) |->
      !page_locked(32'(op_addr[AW-1:PAGE_BITS]), N_PAGES, LOCK_PAGES, BOOT_AT_TOP)); // R8

  AST_ID_LEAVE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy_i && wr_data == 8'hF0 && !in_prog) |=> !id_mode); // R12

  AST_ID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !id_mode |-> id_rdata == 8'h00); // R10

endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(
  .AW(AW), .PAGE_BITS(PAGE_BITS), .LOCK_PAGES(LOCK_PAGES), .BOOT_AT_TOP(BOOT_AT_TOP)
) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .busy_i(busy_i),
  .prot_en(prot_en), .op_valid(op_valid), .op_kind(op_kind), .op_addr(op_addr),
  .id_mode(id_mode), .id_rdata(id_rdata), .seq_break(seq_break), .in_prog(in_prog)
);

// File: tb/flash_cmd_decoder_tb_top.sv
module flash_cmd_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [16:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        busy_i = 1'b0;
  logic        prot_en = 1'b0;
  logic [16:0] rd_addr = '0;

  logic        t_valid, b_valid, t_id, b_id;
  logic [1:0]  t_kind, b_kind;
  logic [16:0] t_addr, b_addr;
  logic [7:0]  t_data, b_data, t_rd, b_rd;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  flash_cmd_decoder #(.BOOT_AT_TOP(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy_i(busy_i), .prot_en(prot_en), .rd_addr(rd_addr),
    .op_valid(t_valid), .op_kind(t_kind), .op_addr(t_addr), .op_data(t_data),
    .id_mode(t_id), .id_rdata(t_rd)
  );

  flash_cmd_decoder #(.BOOT_AT_TOP(1'b0)) dut_b (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy_i(busy_i), .prot_en(prot_en), .rd_addr(rd_addr),
    .op_valid(b_valid), .op_kind(b_kind), .op_addr(b_addr), .op_data(b_data),
    .id_mode(b_id), .id_rdata(b_rd)
  );

  typedef struct packed {
    logic [16:0] a;
    logic [7:0]  d;
    logic        busy;
    logic        v;
    logic [1:0]  k;
    logic [16:0] ea;
    logic [7:0]  ed;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VEC [NV] = '{
    // R3 program
    '{17'h05555, 8'hAA, 1'b0, 1'b0, 2'd0, 17'h0, 8'h0},
    '{17'h02AAA, 8'h55, 1'b0, 1'b0, 2'd0, 17'h0, 8'h0},
    '{17'h05555, 8'hA0, 1'b0, 1'b0, 2'd0, 17'h0, 8'h0},
    '{17'h01234, 8'h5A, 1'b0, 1'b1, 2'd0, 17'h01234, 8'h5A},
    // R4 page erase
    '{17'h05555, 8'hAA, 1'b0, 1'b0, 2'd0, 17'h0, 8'h0},
    '{17'h02AAA, 8'h55, 1'b0, 1'b0, 2'd0, 17'h0, 8'h0},
    '{17'h05555, 8'h80, 1'b0, 1'b0, 2'd0, 17'h0, 8'h0},
    '{17'h05555, 8'hAA, 1'b0, 1'b0, 2'd0, 17'h0, 8'h0},
    '{17'h02AAA, 8'h55, 1'b0, 1'b0, 2'd0, 17'h0, 8'h0},
    '{17'h0A3C7, 8'h30, 1'b0, 1'b1, 2'd1, 17'h0A200, 8'hFF},
    // R5 chip erase
    '{17'h05555, 8'hAA, 1'b0, 1'b0, 2'd0, 17'h0, 8'h0},
    '{17'h02AAA, 8'h55, 1'b0, 1'b0, 2'd0, 17'h0, 8'h0},
    '{17'h05555, 8'h80, 1'b0, 1'b0, 2'd0, 17'h0, 8'h0},
    '{17'h05555, 8'hAA, 1'b0, 1'b0, 2'd0, 17'h0, 8'h0},
    '{17'h02AAA, 8'h55, 1'b0, 1'b0, 2'd0, 17'h0, 8'h0},
    '{17'h05555, 8'h10, 1'b0, 1'b1, 2'd2, 17'h0, 8'hFF},
    // R6 broken sequence then a stray write
    '{17'h05555, 8'hAA, 1'b0, 1'b0, 2'd0, 17'h0, 8'h0},
    '{17'h02AAA, 8'h77, 1'b0, 1'b0, 2'd0, 17'h0, 8'h0},
    '{17'h05555, 8'hA0, 1'b0, 1'b0, 2'd0, 17'h0, 8'h0},
    '{17'h00010, 8'h11, 1'b0, 1'b0, 2'd0, 17'h0, 8'h0},
    // R2 upper address bits ignored
    '{17'h15555, 8'hAA, 1'b0, 1'b0, 2'd0, 17'h0, 8'h0},
    '{17'h0AAAA, 8'h55, 1'b0, 1'b0, 2'd0, 17'h0, 8'h0},
    '{17'h1D555, 8'hA0, 1'b0, 1'b0, 2'd0, 17'h0, 8'h0},
    '{17'h1FFFF, 8'hC3, 1'b0, 1'b1, 2'd0, 17'h1FFFF, 8'hC3},
    // R7 busy write dropped, so A0 breaks the sequence
    '{17'h05555, 8'hAA, 1'b0, 1'b0, 2'd0, 17'h0, 8'h0},
    '{17'h02AAA, 8'h55, 1'b1, 1'b0, 2'd0, 17'h0, 8'h0},
    '{17'h05555, 8'hA0, 1'b0, 1'b0, 2'd0, 17'h0, 8'h0},
    '{17'h00020, 8'h22, 1'b0, 1'b0, 2'd0, 17'h0, 8'h0},
    // R12 F0 as program data (prefix written by directed code below)
    '{17'h05555, 8'hAA, 1'b0, 1'b0, 2'd0, 17'h0, 8'h0},
    '{17'h02AAA, 8'h55, 1'b0, 1'b0, 2'd0, 17'h0, 8'h0}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [16:0] a, input logic [7:0] d, input logic b);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; busy_i = b;
    @(negedge clk);
    wr_en = 1'b0; busy_i = 1'b0;
  endtask

  task automatic unlock();
    do_write(17'h05555, 8'hAA, 1'b0);
    do_write(17'h02AAA, 8'h55, 1'b0);
  endtask

  task automatic erase_prefix();
    unlock();
    do_write(17'h05555, 8'h80, 1'b0);
    unlock();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(t_valid == 0 && b_valid == 0, "R1 op_valid", t_valid, 0);
    chk(t_id == 0 && b_id == 0, "R1 id_mode", t_id, 0);
    chk(t_rd == 8'h00, "R1 id_rdata", t_rd, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      do_write(VEC[i].a, VEC[i].d, VEC[i].busy);
      chk(t_valid == VEC[i].v, "R3/R4/R5/R6/R7 op_valid", t_valid, VEC[i].v);
      if (VEC[i].v) begin
        chk(t_kind == VEC[i].k, "R13 op_kind", t_kind, VEC[i].k);
        chk(t_addr == VEC[i].ea, "R3/R4 op_addr", t_addr, VEC[i].ea);
        chk(t_data == VEC[i].ed, "R3/R5 op_data", t_data, VEC[i].ed);
        @(negedge clk);
        chk(t_valid == 1'b0, "R13 one-cycle pulse", t_valid, 0);
      end
    end

    // R12 F0 in the program data slot is data
    do_write(17'h05555, 8'hA0, 1'b0);
    do_write(17'h00100, 8'hF0, 1'b0);
    chk(t_valid && t_data == 8'hF0, "R12 F0 as program data", t_data, 8'hF0);

    // R8 protection windows, both variants
    prot_en = 1'b1;
    unlock(); do_write(17'h05555, 8'hA0, 1'b0); do_write(17'h1C000, 8'h11, 1'b0);
    chk(!t_valid, "R8 top page 224 refused", t_valid, 0);
    chk(b_valid && b_addr == 17'h1C000, "R8 bottom accepts page 224", b_addr, 17'h1C000);
    unlock(); do_write(17'h05555, 8'hA0, 1'b0); do_write(17'h1BFFF, 8'h33, 1'b0);
    chk(t_valid && t_addr == 17'h1BFFF, "R8 top page 223 allowed", t_addr, 17'h1BFFF);
    unlock(); do_write(17'h05555, 8'hA0, 1'b0); do_write(17'h03FFF, 8'h22, 1'b0);
    chk(t_valid, "R8 top accepts page 31", t_valid, 1);
    chk(!b_valid, "R8 bottom page 31 refused", b_valid, 0);
    unlock(); do_write(17'h05555, 8'hA0, 1'b0); do_write(17'h04000, 8'h44, 1'b0);
    chk(b_valid && b_addr == 17'h04000, "R8 bottom page 32 allowed", b_addr, 17'h04000);
    erase_prefix(); do_write(17'h1FE00, 8'h30, 1'b0);
    chk(!t_valid, "R8 top page erase refused", t_valid, 0);
    chk(b_valid && b_kind == 2'd1 && b_addr == 17'h1FE00, "R8 bottom page erase", b_addr, 17'h1FE00);
    // R9 chip erase refused on both
    erase_prefix(); do_write(17'h05555, 8'h10, 1'b0);
    chk(!t_valid && !b_valid, "R9 chip erase refused", {t_valid, b_valid}, 0);

    // R10/R11 identification mode
    unlock(); do_write(17'h05555, 8'h90, 1'b0);
    chk(t_id && b_id, "R10 id entry", {t_id, b_id}, 3);
    rd_addr = 17'h1FF00; #1;
    chk(t_rd == 8'h7F, "R10 maker code", t_rd, 8'h7F);
    rd_addr = 17'h00001; #1;
    chk(t_rd == 8'hA5, "R10 device top", t_rd, 8'hA5);
    chk(b_rd == 8'hA6, "R10 device bottom", b_rd, 8'hA6);
    rd_addr = 17'h00003; #1;
    chk(t_rd == 8'h1F, "R10 second maker byte", t_rd, 8'h1F);
    rd_addr = 17'h00002; #1;
    chk(t_rd == 8'h01, "R11 guard on", t_rd, 8'h01);
    prot_en = 1'b0; #1;
    chk(t_rd == 8'h00, "R11 guard off", t_rd, 8'h00);
    // R7 busy F0 does not leave ID mode
    do_write(17'h12345, 8'hF0, 1'b1);
    chk(t_id, "R7 busy F0 ignored", t_id, 1);
    // R12 F0 exit
    do_write(17'h12345, 8'hF0, 1'b0);
    rd_addr = 17'h00000; #1;
    chk(!t_id && t_rd == 8'h00, "R12 id exit", {t_id, t_rd}, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule